// File: doc/BRIEF.md
# Host Controller Run/Halt Control and Status Registers

This block keeps the run-control register and the status register of a USB host controller behind a small memory-mapped port for 32-bit registers. Software starts the controller by setting a run flag and stops it by clearing that flag. A stop is not immediate. The block drains outstanding work first and enters the halted state only when a pipeline-idle input reports that nothing is pending. A millisecond-scale timeout, sized from a clock-frequency parameter, turns a drain that never finishes into a sticky controller error.

The status register also carries four other indications. A not-ready flag is raised by hardware reset and dropped once, when initialisation completes. A controller error flag can be cleared only by reset. Two busy flags track a save or restore operation run by an external engine. A save/restore error flag is set when such an operation fails. Software clears it by writing one to it, and starting a new operation also clears it.

The block has two registers. The command register is at byte offset 0x0 and the status register is at byte offset 0x4. Reads return data combinationally for the address on the bus. Writes take effect on the clock edge where the write strobe is high.

Top module: `hcrs_run_status`

## Requirements
- R1: After hardware reset the command register reads 0x00000000 and the status register reads 0x00000801 (halted bit 0 and not-ready bit 11 set). Status bits 31:13 and 7:1 always read zero, and command bits 31:1 always read zero.
- R2: Command bit 0 is the run flag, and a read returns the current run flag. A write of 1 to it while halted (status bit 0 = 1) clears halted, sets the run flag and raises `run_en`, all visible in the cycle after the write.
- R3: A write of 0 to the run flag while running clears the run flag and `run_en` in the next cycle. Halted stays 0 until `pipe_idle` is sampled high. Halted reads 1 in the cycle after that sample.
- R4: If `pipe_idle` is not seen within HALT_CYC = (CLK_HZ/1000) × HALT_MS draining cycles, halted and the controller error flag (status bit 12) are both set on the HALT_CYC-th draining edge.
- R5: The controller error flag is also set by a high `int_err` sample. Only hardware reset clears it, and no register write changes it.
- R6: The not-ready flag (status bit 11) is set by hardware reset. It clears in the cycle after `init_done` is sampled high and then stays 0 until the next hardware reset.
- R7: While not-ready is 1, writes to the command register are ignored. Writes to the status register still take effect.
- R8: A write of 1 to the run flag while halted is 0 pulses `proto_viol` for one cycle, in the cycle after the write, and changes neither the run flag nor halted.
- R9: With no operation active, `save_start` sets save-busy (status bit 8) and `restore_start` sets restore-busy (status bit 9). Save wins if both are high. A start while an operation is active is ignored. `sr_done` clears the active busy flag.
- R10: `sr_fail` while an operation is active clears its busy flag and sets the save/restore error flag (status bit 10). `sr_done` and `sr_fail` with no operation active have no effect.
- R11: The save/restore error flag is cleared by a status write with data bit 10 = 1, unless a failure is recorded in the same cycle. It is also cleared when a new save or restore starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| pipe_idle | input | 1 | No current or queued work remains |
| int_err | input | 1 | Internal error detected |
| init_done | input | 1 | Internal initialisation finished |
| save_start | input | 1 | Save operation begins |
| restore_start | input | 1 | Restore operation begins |
| sr_done | input | 1 | Active save/restore completed |
| sr_fail | input | 1 | Active save/restore failed |
| run_en | output | 1 | Controller in running state |
| proto_viol | output | 1 | One-cycle pulse on an illegal run request |

## Verification
The stop sequence is run three ways: with `pipe_idle` held low for several cycles before it rises, with `pipe_idle` never rising so the timeout fires, and with a repeated run request in the middle of draining. These runs separate a correct drain from an early halt, a missing timeout and an illegal restart. The save/restore tracker gets a save and a restore started together, a start while busy, completion, failure, and error clearing both by a write of one and by a new start. This checks the priority between clear and set. Writes made before initialisation completes show that command writes are blocked while status writes still act. A second reset then checks that only reset clears the sticky flags.

// File: rtl/hcrs_pkg.sv
package hcrs_pkg;

   localparam int unsigned REG_DW    = 32;
   localparam int unsigned OFS_CMD   = 0;
   localparam int unsigned OFS_STS   = 4;

   localparam int unsigned CB_RUN    = 0;
   localparam int unsigned SB_HALT   = 0;
   localparam int unsigned SB_SAVE   = 8;
   localparam int unsigned SB_REST   = 9;
   localparam int unsigned SB_SRERR  = 10;
   localparam int unsigned SB_NRDY   = 11;
   localparam int unsigned SB_CERR   = 12;

   typedef enum logic [1:0] {
      PH_HALTED   = 2'd0,
      PH_RUNNING  = 2'd1,
      PH_DRAINING = 2'd2
   } run_phase_e;

   typedef struct packed {
      logic cerr;
      logic nrdy;
      logic srerr;
      logic rest;
      logic save;
      logic halted;
   } stat_flags_t;

endpackage

// File: rtl/hcrs_ready_track.sv
module hcrs_ready_track (
   input  logic clk,
   input  logic rst_n,
   input  logic init_done,
   output logic not_ready
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         not_ready <= 1'b1;
      else if (init_done)
         not_ready <= 1'b0;
   end

   // R6: once clear, the flag never returns without a hardware reset
   assert_nrdy_stays_clear_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !not_ready |=> !not_ready);

endmodule

// File: rtl/hcrs_run_ctrl.sv
module hcrs_run_ctrl
   import hcrs_pkg::*;
#(
   parameter int unsigned HALT_CYC = 1600000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   input  logic pipe_idle,
   input  logic int_err,
   output logic run_bit,
   output logic halted,
   output logic ctrl_err,
   output logic proto_viol
);

   localparam int unsigned CNT_W = $clog2(HALT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALT_CYC - 1);

   initial begin
      assert (HALT_CYC >= 2)
         else $error("hcrs_run_ctrl: HALT_CYC must be at least 2");
   end

   run_phase_e       phase;
   logic [CNT_W-1:0] drain_cnt;
   logic             cnt_last;
   logic             tmo_hit;

   assign cnt_last = (drain_cnt == CNT_LAST);
   assign tmo_hit  = (phase == PH_DRAINING) && !pipe_idle && cnt_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_HALTED;
         drain_cnt <= '0;
      end else begin
         unique case (phase)
            PH_HALTED: begin
               if (set_req) phase <= PH_RUNNING;
            end
            PH_RUNNING: begin
               if (clr_req) begin
                  phase     <= PH_DRAINING;
                  drain_cnt <= '0;
               end
            end
            PH_DRAINING: begin
               if (pipe_idle || cnt_last)
                  phase <= PH_HALTED;
               else
                  drain_cnt <= drain_cnt + 1'b1;
            end
            default: phase <= PH_HALTED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_err   <= 1'b0;
         proto_viol <= 1'b0;
      end else begin
         ctrl_err   <= ctrl_err | int_err | tmo_hit;
         proto_viol <= set_req && (phase != PH_HALTED);
      end
   end

   assign run_bit = (phase == PH_RUNNING);
   assign halted  = (phase == PH_HALTED);

   // R2: a run request from halted starts the controller next cycle
   assert_run_from_halt_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && halted) |=> (run_bit && !halted));

   // R3: halting is only reached from the draining phase
   assert_halt_after_drain_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> ($past(phase) == PH_DRAINING));

   // R4: an expired drain window halts with the error flag raised
   assert_timeout_sets_err_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      tmo_hit |=> (ctrl_err && halted));

   // R5: the controller error flag is sticky
   assert_err_sticky_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_err |=> ctrl_err);

   // R8: an illegal run request is flagged and does not restart draining
   assert_viol_flagged_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && !halted) |=> proto_viol);
   assert_viol_no_restart_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && phase == PH_DRAINING) |=> !run_bit);

endmodule

// File: rtl/hcrs_sr_track.sv
module hcrs_sr_track (
   input  logic clk,
   input  logic rst_n,
   input  logic save_start,
   input  logic restore_start,
   input  logic sr_done,
   input  logic sr_fail,
   input  logic w1c_clr,
   output logic save_busy,
   output logic rest_busy,
   output logic sr_err
);

   logic op_idle;
   assign op_idle = !save_busy && !rest_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         save_busy <= 1'b0;
         rest_busy <= 1'b0;
         sr_err    <= 1'b0;
      end else if (op_idle) begin
         if (save_start) begin
            save_busy <= 1'b1;
            sr_err    <= 1'b0;
         end else if (restore_start) begin
            rest_busy <= 1'b1;
            sr_err    <= 1'b0;
         end else if (w1c_clr) begin
            sr_err    <= 1'b0;
         end
      end else if (sr_fail) begin
         save_busy <= 1'b0;
         rest_busy <= 1'b0;
         sr_err    <= 1'b1;
      end else begin
         if (sr_done) begin
            save_busy <= 1'b0;
            rest_busy <= 1'b0;
         end
         if (w1c_clr) sr_err <= 1'b0;
      end
   end

   // R9: at most one operation in flight
   assert_sr_exclusive_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({save_busy, rest_busy}));

   // R10: a failure ends the operation and records the error
   assert_fail_sets_err_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!op_idle && sr_fail) |=> (sr_err && !save_busy && !rest_busy));

   // R11: write-one-to-clear works unless a failure lands in the same cycle
   assert_w1c_clears_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_clr && !(sr_fail && !op_idle)) |=> !sr_err);

endmodule

// File: rtl/hcrs_run_status.sv
module hcrs_run_status
   import hcrs_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 100000000,
   parameter int unsigned HALT_MS  = 16,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rd_data,
   input  logic              pipe_idle,
   input  logic              int_err,
   input  logic              init_done,
   input  logic              save_start,
   input  logic              restore_start,
   input  logic              sr_done,
   input  logic              sr_fail,
   output logic              run_en,
   output logic              proto_viol
);

   localparam int unsigned HALT_CYC = (CLK_HZ / 1000) * HALT_MS;

   initial begin
      assert (CLK_HZ >= 1000 && (CLK_HZ % 1000) == 0)
         else $error("hcrs_run_status: CLK_HZ must be a multiple of 1000");
      assert (HALT_MS >= 1)
         else $error("hcrs_run_status: HALT_MS must be at least 1");
      assert (ADDR_W >= 3)
         else $error("hcrs_run_status: ADDR_W too small for the register offsets");
      assert (REG_DW == 32)
         else $error("hcrs_run_status: register width must be 32");
   end

   logic        hit_cmd, hit_sts;
   logic        cmd_wr, sts_wr;
   logic        not_ready;
   logic        run_bit, halted_f, ctrl_err;
   logic        save_busy, rest_busy, sr_err;
   stat_flags_t flags;
   logic [31:0] sts_word, cmd_word, rd_comb;

   assign hit_cmd = (addr == ADDR_W'(OFS_CMD));
   assign hit_sts = (addr == ADDR_W'(OFS_STS));
   assign cmd_wr  = wr_en && hit_cmd && !not_ready;
   assign sts_wr  = wr_en && hit_sts;

   hcrs_ready_track u_ready (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_done (init_done),
      .not_ready (not_ready)
   );

   hcrs_run_ctrl #(
      .HALT_CYC (HALT_CYC)
   ) u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_req    (cmd_wr && wdata[CB_RUN]),
      .clr_req    (cmd_wr && !wdata[CB_RUN]),
      .pipe_idle  (pipe_idle),
      .int_err    (int_err),
      .run_bit    (run_bit),
      .halted     (halted_f),
      .ctrl_err   (ctrl_err),
      .proto_viol (proto_viol)
   );

   hcrs_sr_track u_sr (
      .clk           (clk),
      .rst_n         (rst_n),
      .save_start    (save_start),
      .restore_start (restore_start),
      .sr_done       (sr_done),
      .sr_fail       (sr_fail),
      .w1c_clr       (sts_wr && wdata[SB_SRERR]),
      .save_busy     (save_busy),
      .rest_busy     (rest_busy),
      .sr_err        (sr_err)
   );

   assign flags = '{cerr: ctrl_err, nrdy: not_ready, srerr: sr_err,
                    rest: rest_busy, save: save_busy, halted: halted_f};

   always_comb begin
      sts_word           = '0;
      sts_word[SB_HALT]  = flags.halted;
      sts_word[SB_SAVE]  = flags.save;
      sts_word[SB_REST]  = flags.rest;
      sts_word[SB_SRERR] = flags.srerr;
      sts_word[SB_NRDY]  = flags.nrdy;
      sts_word[SB_CERR]  = flags.cerr;
      cmd_word           = '0;
      cmd_word[CB_RUN]   = run_bit;
   end

   assign rd_comb = hit_cmd ? cmd_word : (hit_sts ? sts_word : '0);
   assign run_en  = run_bit;

   generate
      if (READ_REG) begin : g_rd_reg
         logic [31:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_comb;
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = rd_comb;
      end
   endgenerate

   // R7: command writes before initialisation completes leave the controller stopped
   assert_blocked_cmd_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_cmd && not_ready) |=> !run_en);

   // R1: reserved status bits never read as one
   assert_reserved_zero_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (sts_word[31:13] == '0) && (sts_word[7:1] == '0));

endmodule

// File: tb/hcrs_run_status_bench.sv
module hcrs_run_status_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TB_CLK_HZ  = 100000;
   localparam int TB_HALT_MS = 16;
   localparam int LIM        = (TB_CLK_HZ / 1000) * TB_HALT_MS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   logic        pipe_idle = 1'b0, int_err = 1'b0, init_done = 1'b0;
   logic        save_start = 1'b0, restore_start = 1'b0;
   logic        sr_done = 1'b0, sr_fail = 1'b0;
   logic        run_en, proto_viol;

   int total = 0;
   int bad   = 0;
   bit cmp_on = 1'b0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hcrs_run_status #(
      .CLK_HZ  (TB_CLK_HZ),
      .HALT_MS (TB_HALT_MS),
      .ADDR_W  (4)
   ) u_hcrs_run_status (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_data(rd_data), .pipe_idle(pipe_idle), .int_err(int_err),
      .init_done(init_done), .save_start(save_start),
      .restore_start(restore_start), .sr_done(sr_done), .sr_fail(sr_fail),
      .run_en(run_en), .proto_viol(proto_viol)
   );

   // behavioural reference model
   bit m_halted, m_run, m_drain, m_err, m_nr, m_save, m_rest, m_srerr, m_viol;
   int m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_halted = 1; m_run = 0; m_drain = 0; m_err = 0; m_nr = 1;
         m_save = 0; m_rest = 0; m_srerr = 0; m_viol = 0; m_cnt = 0;
      end else begin
         bit w_cmd, w_sts, busy;
         w_cmd = wr_en && addr == 4'h0 && !m_nr;
         w_sts = wr_en && addr == 4'h4;
         m_viol = w_cmd && wdata[0] && !m_halted;
         if (m_halted) begin
            if (w_cmd && wdata[0]) begin m_halted = 0; m_run = 1; end
         end else if (m_run) begin
            if (w_cmd && !wdata[0]) begin m_run = 0; m_drain = 1; m_cnt = 0; end
         end else if (m_drain) begin
            if (pipe_idle) begin m_drain = 0; m_halted = 1; end
            else if (m_cnt == LIM - 1) begin m_drain = 0; m_halted = 1; m_err = 1; end
            else m_cnt++;
         end
         if (int_err) m_err = 1;
         if (init_done) m_nr = 0;
         busy = m_save || m_rest;
         if (!busy) begin
            if (w_sts && wdata[10]) m_srerr = 0;
            if (save_start) begin m_save = 1; m_srerr = 0; end
            else if (restore_start) begin m_rest = 1; m_srerr = 0; end
         end else begin
            if (w_sts && wdata[10]) m_srerr = 0;
            if (sr_fail) begin m_save = 0; m_rest = 0; m_srerr = 1; end
            else if (sr_done) begin m_save = 0; m_rest = 0; end
         end
      end
   end

   function automatic logic [31:0] m_sts();
      return {19'b0, m_err, m_nr, m_srerr, m_rest, m_save, 7'b0, m_halted};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison of registered outputs
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2 R3 run_en", {31'b0, run_en}, {31'b0, m_run});
         chk("R8 proto_viol", {31'b0, proto_viol}, {31'b0, m_viol});
      end
   end

   task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      wr_en = 0; addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0; wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      cmp_on = 0; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1; cmp_on = 1;
   endtask

   task automatic pulse_init();
      @(negedge clk); init_done = 1; @(negedge clk); init_done = 0;
   endtask

   task automatic pulse_sr(bit s, bit r, bit d, bit f);
      @(negedge clk);
      save_start = s; restore_start = r; sr_done = d; sr_fail = f;
      @(negedge clk);
      save_start = 0; restore_start = 0; sr_done = 0; sr_fail = 0;
   endtask

   initial begin
      do_reset();
      // R1 reset values
      rd_chk(4'h0, 32'h0, "R1 cmd reset");
      rd_chk(4'h4, 32'h0000_0801, "R1 status reset");

      // R7 command write blocked while not ready
      wr(4'h0, 32'h1);
      rd_chk(4'h0, 32'h0, "R7 cmd write ignored");
      rd_chk(4'h4, 32'h0000_0801, "R7 still halted");
      // R7 status writes still act: build an error then clear it
      pulse_sr(1, 0, 0, 0);
      rd_chk(4'h4, 32'h0000_0901, "R9 save busy");
      pulse_sr(0, 0, 0, 1);
      rd_chk(4'h4, 32'h0000_0C01, "R10 fail sets error");
      wr(4'h4, 32'h0000_0400);
      rd_chk(4'h4, 32'h0000_0801, "R7 R11 w1c while not ready");

      // R6 init done clears not-ready for good
      pulse_init();
      rd_chk(4'h4, 32'h0000_0001, "R6 not-ready cleared");

      // R2 start
      wr(4'h0, 32'h1);
      rd_chk(4'h0, 32'h1, "R2 run readback");
      rd_chk(4'h4, 32'h0, "R2 halted cleared");
      // R8 repeated run request
      wr(4'h0, 32'h1);
      rd_chk(4'h4, 32'h0, "R8 state unchanged");

      // R3 drain with delayed idle
      wr(4'h0, 32'h0);
      rd_chk(4'h0, 32'h0, "R3 run cleared");
      wr(4'h0, 32'h1);  // R8 illegal during drain
      repeat (5) @(negedge clk);
      rd_chk(4'h4, 32'h0, "R3 not halted before idle");
      rd_chk(4'h4, 32'h0, "R3 R8 still draining");
      @(negedge clk); pipe_idle = 1;
      @(negedge clk); pipe_idle = 0;
      rd_chk(4'h4, 32'h1, "R3 halted after idle");
      rd_chk(4'h4, m_sts(), "R3 model status");

      // R4 timeout path
      wr(4'h0, 32'h1);
      wr(4'h0, 32'h0);
      repeat (LIM - 10) @(negedge clk);
      rd_chk(4'h4, 32'h0, "R4 before limit");
      repeat (15) @(negedge clk);
      rd_chk(4'h4, 32'h0000_1001, "R4 timeout error and halt");

      // R5 sticky against writes
      wr(4'h4, 32'hFFFF_FFFF);
      wr(4'h0, 32'h0);
      rd_chk(4'h4, 32'h0000_1001, "R5 error not writable");
      pulse_init();
      rd_chk(4'h4, 32'h0000_1001, "R6 second init no change");

      // R9 ordering and busy handling
      pulse_sr(1, 1, 0, 0);
      rd_chk(4'h4, 32'h0000_1101, "R9 save wins tie");
      pulse_sr(0, 1, 0, 0);
      rd_chk(4'h4, 32'h0000_1101, "R9 start while busy ignored");
      pulse_sr(0, 0, 1, 0);
      rd_chk(4'h4, 32'h0000_1001, "R9 done clears save");
      pulse_sr(0, 0, 1, 1);
      rd_chk(4'h4, 32'h0000_1001, "R10 done or fail while idle ignored");
      pulse_sr(0, 1, 0, 0);
      rd_chk(4'h4, 32'h0000_1201, "R9 restore busy");
      // R10 plus R11 same-cycle priority
      @(negedge clk); sr_fail = 1; wr_en = 1; addr = 4'h4; wdata = 32'h400;
      @(negedge clk); sr_fail = 0; wr_en = 0; wdata = '0;
      rd_chk(4'h4, 32'h0000_1401, "R10 R11 fail beats w1c");
      pulse_sr(1, 0, 0, 0);
      rd_chk(4'h4, 32'h0000_1101, "R11 start clears error");
      pulse_sr(0, 0, 0, 1);
      pulse_sr(0, 0, 0, 0);
      wr(4'h4, 32'h0000_0400);
      rd_chk(4'h4, 32'h0000_1001, "R11 w1c when idle");
      rd_chk(4'h8, 32'h0, "R1 unmapped reads zero");

      // reset clears sticky flags, int_err path
      do_reset();
      rd_chk(4'h4, 32'h0000_0801, "R1 R6 reset restores not-ready");
      pulse_init();
      @(negedge clk); int_err = 1; @(negedge clk); int_err = 0;
      rd_chk(4'h4, 32'h0000_1001, "R5 int_err sets error");
      rd_chk(4'h4, m_sts(), "R5 model status");

      @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule